// File: doc/BRIEF.md
# Memory Test Data Pattern Generator

This block supplies the data words for a memory traffic tester. Each beat arrives as an address with a valid strobe. The block returns one registered data word per beat. The same word serves as the write data and as the expected read data. A three-bit mode code chooses one of three patterns:

- a single set bit moving across the word;
- a single cleared bit moving across the word;
- a pseudo-random word from a 32-bit linear feedback shift register.

The pattern is tied to the address. In the moving-bit modes, the first address of a run fixes the starting bit. For the pseudo-random mode, the first address of a run loads the shift register.

A run is an unbroken sequence of valid beats that share one mode code and one address-mode code. The pseudo-random pattern is only accepted with a sequential or pseudo-random address mode. Any other address mode causes a registered error indication, and that beat produces no data.

Top module: `mem_pattern_gen`

## Requirements
- R1: Each beat taken while `addrValid` is high produces `dataValid` high with its word on the next cycle. A cycle with no accepted beat gives `dataValid` low and `dataOut` zero on the next cycle. During reset all three outputs are zero.
- R2: Mode code 5 (moving one): `dataOut` has exactly one bit set, and it sits at the current position.
- R3: Mode code 6 (moving zero): `dataOut` has exactly one bit clear, and it sits at the current position. All other bits are set.
- R4: The start position is (address >> log2(DATA_W/8)) mod DATA_W. It is taken from the first beat of a run. Addresses presented on later beats of the same run have no effect on the position.
- R5: The position rises by one on each later beat of a run. After DATA_W-1 it wraps to 0.
- R6: A new run begins in either of two cases. The first case is a valid beat whose previous cycle had no valid beat. The second is a valid beat whose mode code or address-mode code differs from the previous beat. A new run restarts the position or reloads the register.
- R7: Mode code 7 (pseudo-random): on the first beat of a run the register is loaded with address bits 31:0, and that value is the first output. Each later beat outputs the next state, where next = {s[30:0], s[31]^s[21]^s[1]^s[0]}. For output bit i, dataOut[i] = s[i mod 32].
- R8: A load value of zero is replaced by 32'h0000_0001.
- R9: The address-mode codes are 0 fixed, 1 sequential, 2 pseudo-random and 3 reserved. With mode code 7, only codes 1 and 2 are legal. A valid beat that breaks this rule gives `errFlag` high on the next cycle, with `dataValid` low and `dataOut` zero.
- R10: A valid beat with any mode code other than 5, 6 or 7 gives `dataValid` low, `dataOut` zero and `errFlag` low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| modeCode | input | 3 | Pattern selector (5, 6, 7) |
| addr | input | ADDR_W | Beat address |
| addrValid | input | 1 | Beat strobe |
| addrMode | input | 2 | Address-mode code of the traffic source |
| dataOut | output | DATA_W | Registered pattern word |
| dataValid | output | 1 | Pattern word valid |
| errFlag | output | 1 | Illegal pseudo-random/address-mode combination |

## Verification
A wrong position counter shows up on the very next beat of a run: the moving bit lands in the wrong place or fails to wrap. A stale or wrongly loaded shift register gives a wrong word from the first beat of a run onward. Broken run detection shows as a pattern that carries on when it should restart after a gap, a mode change or an address-mode change. Each of these faults is visible one cycle after the beat that triggers it, so the directed runs compare every beat against a model of the position and the register.

// File: rtl/patgen_pkg.sv
package patgen_pkg;

  localparam logic [2:0] MODE_WALK1 = 3'd5;
  localparam logic [2:0] MODE_WALK0 = 3'd6;
  localparam logic [2:0] MODE_PRBS  = 3'd7;

  localparam logic [1:0] AMODE_FIXED = 2'd0;
  localparam logic [1:0] AMODE_SEQ   = 2'd1;
  localparam logic [1:0] AMODE_PRND  = 2'd2;

  localparam int unsigned LFSR_W = 32;
  localparam logic [LFSR_W-1:0] SEED_SUBST = 32'h0000_0001;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_WALK1 = 2'd1,
    KIND_WALK0 = 2'd2,
    KIND_PRBS  = 2'd3
  } beatKind_t;

  typedef struct packed {
    logic      fire;
    logic      restart;
    logic      illegal;
    beatKind_t kind;
  } ctrlStrobe_t;

  function automatic logic [LFSR_W-1:0] lfsrStep(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

endpackage

// File: rtl/patgen_ctrl.sv
module patgen_ctrl
  import patgen_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  modeCode,
  input  logic        addrValid,
  input  logic [1:0]  addrMode,
  output ctrlStrobe_t strobe
);

  logic       prevValid;
  logic [2:0] prevMode;
  logic [1:0] prevAddrMode;
  beatKind_t  kindDec;
  logic       amodeOk;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevValid    <= 1'b0;
      prevMode     <= 3'd0;
      prevAddrMode <= 2'd0;
    end else begin
      prevValid <= addrValid;
      if (addrValid) begin
        prevMode     <= modeCode;
        prevAddrMode <= addrMode;
      end
    end
  end

  always_comb begin
    case (modeCode)
      MODE_WALK1: kindDec = KIND_WALK1;
      MODE_WALK0: kindDec = KIND_WALK0;
      MODE_PRBS:  kindDec = KIND_PRBS;
      default:    kindDec = KIND_NONE;
    endcase
  end

  assign amodeOk = (addrMode == AMODE_SEQ) || (addrMode == AMODE_PRND);

  always_comb begin
    strobe.kind    = kindDec;
    strobe.illegal = addrValid && (kindDec == KIND_PRBS) && !amodeOk;
    strobe.fire    = addrValid && (kindDec != KIND_NONE) && !strobe.illegal;
    strobe.restart = strobe.fire &&
                     (!prevValid || (modeCode != prevMode) || (addrMode != prevAddrMode));
  end

  // R6: a beat following an idle cycle always opens a new run
  p_restart_after_gap_r6: assert property (@(posedge clk) disable iff (rst)
    !addrValid |=> (!strobe.fire || strobe.restart));

  // R9: illegal and fire are never raised together
  p_illegal_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(strobe.illegal && strobe.fire));

endmodule

// File: rtl/patgen_dpath.sv
module patgen_dpath
  import patgen_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic              errFlag
);

  localparam int unsigned BYTE_SHIFT = $clog2(DATA_W / 8);
  localparam int unsigned POS_W      = $clog2(DATA_W);

  logic [POS_W-1:0]  posReg, startPos, curPos;
  logic [LFSR_W-1:0] lfsrReg, seedRaw, seedVal, curLfsr;
  logic [DATA_W-1:0] walkVec, prbsVec, nextData;
  beatKind_t         outKind;
  logic              outCont;

  assign startPos = addr[BYTE_SHIFT +: POS_W];
  assign curPos   = strobe.restart ? startPos : posReg;

  generate
    if (ADDR_W >= LFSR_W) begin : g_seed_trunc
      assign seedRaw = addr[LFSR_W-1:0];
    end else begin : g_seed_pad
      assign seedRaw = {{(LFSR_W-ADDR_W){1'b0}}, addr};
    end
  endgenerate

  assign seedVal = (seedRaw == '0) ? SEED_SUBST : seedRaw;
  assign curLfsr = strobe.restart ? seedVal : lfsrReg;

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_bits
      assign walkVec[i] = (curPos == POS_W'(i));
      assign prbsVec[i] = curLfsr[i % LFSR_W];
    end
  endgenerate

  always_comb begin
    case (strobe.kind)
      KIND_WALK1: nextData = walkVec;
      KIND_WALK0: nextData = ~walkVec;
      KIND_PRBS:  nextData = prbsVec;
      default:    nextData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      posReg  <= '0;
      lfsrReg <= SEED_SUBST;
    end else if (strobe.fire) begin
      if (strobe.kind == KIND_PRBS) lfsrReg <= lfsrStep(curLfsr);
      else                          posReg  <= curPos + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataOut   <= '0;
      dataValid <= 1'b0;
      errFlag   <= 1'b0;
      outKind   <= KIND_NONE;
      outCont   <= 1'b0;
    end else begin
      dataOut   <= strobe.fire ? nextData : '0;
      dataValid <= strobe.fire;
      errFlag   <= strobe.illegal;
      outKind   <= strobe.fire ? strobe.kind : KIND_NONE;
      outCont   <= strobe.fire && !strobe.restart;
    end
  end

  function automatic logic [DATA_W-1:0] rotl1(input logic [DATA_W-1:0] v);
    return {v[DATA_W-2:0], v[DATA_W-1]};
  endfunction

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    strobe.fire |=> dataValid);

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (rst)
    !strobe.fire |=> (!dataValid && dataOut == '0));

  p_walk1_single_r2: assert property (@(posedge clk) disable iff (rst)
    (dataValid && outKind == KIND_WALK1) |-> $countones(dataOut) == 1);

  p_walk0_single_r3: assert property (@(posedge clk) disable iff (rst)
    (dataValid && outKind == KIND_WALK0) |-> $countones(~dataOut) == 1);

  p_walk_step_r5: assert property (@(posedge clk) disable iff (rst)
    (dataValid && outCont && outKind != KIND_PRBS) |-> dataOut == rotl1($past(dataOut)));

  p_lfsr_live_r8: assert property (@(posedge clk) disable iff (rst)
    lfsrReg != '0);

  p_err_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    errFlag |-> (!dataValid && dataOut == '0));

endmodule

// File: rtl/mem_pattern_gen.sv
module mem_pattern_gen
  import patgen_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        modeCode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              addrValid,
  input  logic [1:0]        addrMode,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic              errFlag
);

  ctrlStrobe_t strobe;

  patgen_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .modeCode  (modeCode),
    .addrValid (addrValid),
    .addrMode  (addrMode),
    .strobe    (strobe)
  );

  patgen_dpath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .addr      (addr),
    .dataOut   (dataOut),
    .dataValid (dataValid),
    .errFlag   (errFlag)
  );

  // R10: beats with an unsupported mode code never produce an error
  p_unsupported_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (addrValid && modeCode != MODE_WALK1 && modeCode != MODE_WALK0 &&
     modeCode != MODE_PRBS) |=> !errFlag);

endmodule

// File: tb/mem_pattern_gen_test.sv
module mem_pattern_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [2:0]    modeCode;
  logic [31:0]   addr;
  logic          addrValid;
  logic [1:0]    addrMode;
  logic [DW-1:0] dataOut;
  logic          dataValid;
  logic          errFlag;

  int testsRun = 0;
  int testsFailed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_pattern_gen #(.DATA_W(DW), .ADDR_W(32)) uut (
    .clk(clk), .rst(rst), .modeCode(modeCode), .addr(addr),
    .addrValid(addrValid), .addrMode(addrMode),
    .dataOut(dataOut), .dataValid(dataValid), .errFlag(errFlag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] modelStep(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic goIdle();
    addrValid = 1'b0;
    @(negedge clk);
    check("R1 idle valid", {31'b0, dataValid}, 32'd0);
    check("R1 idle data", dataOut, 32'd0);
  endtask

  // Moving-bit run; addresses after the first beat are scrambled (R4)
  task automatic runWalk(input logic [2:0] m, input logic [31:0] a, input int n,
                         input logic [1:0] am, input bit idleAfter);
    for (int k = 0; k < n; k++) begin
      modeCode = m; addrMode = am; addrValid = 1'b1;
      addr = (k == 0) ? a : (a ^ (32'h0000_0044 * k));
      @(negedge clk);
      begin
        int pos;
        logic [31:0] expv;
        pos = ((a >> 2) + k) % DW;
        expv = 32'd1 << pos;
        if (m == 3'd6) expv = ~expv;
        check("R1 walk valid", {31'b0, dataValid}, 32'd1);
        check(m == 3'd5 ? "R2 R4 R5 walk-one word" : "R3 R4 R5 walk-zero word", dataOut, expv);
        check("R9 no err in walk", {31'b0, errFlag}, 32'd0);
      end
    end
    if (idleAfter) goIdle();
  endtask

  task automatic runPrbs(input logic [31:0] seed, input int n,
                         input logic [1:0] am, input bit idleAfter);
    logic [31:0] s;
    s = (seed == 32'd0) ? 32'h0000_0001 : seed;
    for (int k = 0; k < n; k++) begin
      modeCode = 3'd7; addrMode = am; addrValid = 1'b1;
      addr = (k == 0) ? seed : (seed + 32'h40 * k);
      @(negedge clk);
      check("R7 prbs valid", {31'b0, dataValid}, 32'd1);
      check(seed == 32'd0 ? "R8 zero-seed word" : "R7 prbs word", dataOut, s);
      s = modelStep(s);
    end
    if (idleAfter) goIdle();
  endtask

  task automatic testIllegal(input logic [1:0] am);
    modeCode = 3'd7; addrMode = am; addrValid = 1'b1; addr = 32'h1234_5678;
    @(negedge clk);
    check("R9 err raised", {31'b0, errFlag}, 32'd1);
    check("R9 no valid on err", {31'b0, dataValid}, 32'd0);
    check("R9 zero data on err", dataOut, 32'd0);
    goIdle();
    check("R9 err clears", {31'b0, errFlag}, 32'd0);
  endtask

  task automatic testUnsupported(input logic [2:0] m);
    modeCode = m; addrMode = 2'd1; addrValid = 1'b1; addr = 32'h0000_0010;
    @(negedge clk);
    check("R10 no valid", {31'b0, dataValid}, 32'd0);
    check("R10 no err", {31'b0, errFlag}, 32'd0);
    check("R10 zero data", dataOut, 32'd0);
    goIdle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    testsFailed++;
    $display("FAIL R1 watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    rst = 1'b1; modeCode = 3'd0; addr = '0; addrValid = 1'b0; addrMode = 2'd0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'b0, dataValid}, 32'd0);
    check("R1 reset data", dataOut, 32'd0);
    check("R1 reset err", {31'b0, errFlag}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    runWalk(3'd5, 32'h0000_0010, 5, 2'd1, 1'b1);   // R2 start at bit 4
    runWalk(3'd5, 32'h0000_007C, 4, 2'd0, 1'b1);   // R5 wrap 31 -> 0
    runWalk(3'd5, 32'h0000_0013, 2, 2'd1, 1'b1);   // R4 low bits dropped
    runWalk(3'd6, 32'h0000_0088, 4, 2'd2, 1'b1);   // R3 start at bit 2
    runWalk(3'd6, 32'h0000_00FC, 3, 2'd1, 1'b1);   // R3 R5 wrap
    // R6: mode change with no gap restarts from the new address
    runWalk(3'd5, 32'h0000_0020, 3, 2'd1, 1'b0);
    runWalk(3'd6, 32'h0000_0040, 3, 2'd1, 1'b1);
    // R6: address-mode change with no gap restarts the walk
    runWalk(3'd5, 32'h0000_0008, 3, 2'd1, 1'b0);
    runWalk(3'd5, 32'h0000_0030, 2, 2'd2, 1'b1);

    runPrbs(32'h1234_5678, 6, 2'd1, 1'b1);          // R7 sequential
    runPrbs(32'h1234_5678, 3, 2'd2, 1'b1);          // R6 reseed after gap
    runPrbs(32'h0000_0000, 4, 2'd2, 1'b1);          // R8
    runPrbs(32'hDEAD_BEEF, 3, 2'd1, 1'b0);          // R6 addr-mode change
    runPrbs(32'h0BAD_F00D, 3, 2'd2, 1'b1);

    testIllegal(2'd0);                               // R9 fixed
    testIllegal(2'd3);                               // R9 reserved
    testUnsupported(3'd2);                           // R10
    testUnsupported(3'd0);                           // R10

    runWalk(3'd5, 32'h0000_0004, 2, 2'd1, 1'b1);    // R6 after error/unsupported

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule